// File: doc/BRIEF.md
# Opcode-Mapped Sixteen-Bit Arithmetic and Logic Unit

This block is the arithmetic core for a small load/store processor. It takes two operands and a four-bit operation select. It returns a result word and a single flag bit. The select codes are the processor's major opcode values, so the instruction decoder can pass that field to the unit without translating it. The unit provides add, subtract, OR, AND, NOT, XOR, logical right shift, truncated multiply, and an equality compare that reports only through the flag.

The unit is purely combinational and holds no state. The result and the flag follow the present inputs within one clock period of the surrounding pipeline. The style's valid/ready rules do not apply, because no data is held or transferred: there is no back-pressure, and a new operand pair may be applied on every cycle. Select codes that belong to the processor's non-arithmetic instructions still give defined outputs: a zero result and a cleared flag. The decoder can therefore leave the unit connected at all times.

Top module: `opmap_alu`

## Requirements
- R1: Select 4'b0011 gives q = a + b, wrapped modulo 2^16, with no carry output.
- R2: Select 4'b0100 gives q = a - b, wrapped modulo 2^16.
- R3: Select 4'b0101 gives a OR b, select 4'b0110 gives a AND b, and select 4'b1000 gives a XOR b, each bit by bit.
- R4: Select 4'b0111 gives the bitwise inverse of a, and the value of b has no effect on q or flag.
- R5: Select 4'b1010 shifts a right by the unsigned amount in b[3:0], from 0 to 15. Zeros fill the vacated high bits, and b[15:4] has no effect.
- R6: Select 4'b1011 gives the low 16 bits of the product a * b.
- R7: Select 4'b1100 sets flag to 1 when a equals b and to 0 otherwise, and drives q to 16'h0000.
- R8: For the codes in R1 to R6, flag is 1 exactly when the 16-bit q is 16'h0000.
- R9: Select codes 4'b0000, 4'b0001, 4'b0010, 4'b1001, 4'b1101, 4'b1110 and 4'b1111 drive q to 16'h0000 and flag to 0, whatever the operands.
- R10: q and flag depend only on the present inputs. A change on a, b or sel reaches the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel_i | input | 4 | Operation select, equal to the processor's major opcode |
| a_i | input | WIDTH (16) | First operand; the operand that is shifted or inverted |
| b_i | input | WIDTH (16) | Second operand; its low four bits give the shift amount |
| q_o | output | WIDTH (16) | Result word |
| flag_o | output | 1 | Equality for compare; otherwise set when the result is zero |

## Verification
The bench builds the unit only at its default WIDTH of 16, which gives a four-bit shift amount. At this width every shift distance from 0 to 15 can be driven directly, and it is driven with the upper bits of b set so that they are shown to be ignored. The 16-bit width also makes the wrap cases easy to reach: all-ones plus one, zero minus one, and products whose low half is zero. These cases test the zero flag on the wrapped value and not on the full result. Random operands under every select code, including the seven non-arithmetic codes, test the remaining behaviour against a model in the bench.

// File: rtl/opmap_alu_pkg.sv
package opmap_alu_pkg;

  localparam int unsigned SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    OP_NA0  = 4'b0000,
    OP_NA1  = 4'b0001,
    OP_NA2  = 4'b0010,
    OP_ADD  = 4'b0011,
    OP_SUB  = 4'b0100,
    OP_OR   = 4'b0101,
    OP_AND  = 4'b0110,
    OP_NOT  = 4'b0111,
    OP_XOR  = 4'b1000,
    OP_NA9  = 4'b1001,
    OP_SHR  = 4'b1010,
    OP_MUL  = 4'b1011,
    OP_CMP  = 4'b1100,
    OP_NA13 = 4'b1101,
    OP_NA14 = 4'b1110,
    OP_NA15 = 4'b1111
  } alu_op_e;

endpackage

// File: rtl/opmap_alu_arith.sv
module opmap_alu_arith #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] diff_o,
  output logic [WIDTH-1:0] prod_o
);
  // All three results are kept at WIDTH bits, so each one wraps.
  always_comb begin
    sum_o  = a_i + b_i;
    diff_o = a_i - b_i;
    prod_o = a_i * b_i;
  end
endmodule

// File: rtl/opmap_alu_bitops.sv
module opmap_alu_bitops #(
  parameter int unsigned WIDTH = 16,
  localparam int unsigned SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] inv_o,
  output logic [WIDTH-1:0] xor_o,
  output logic [WIDTH-1:0] shr_o
);
  logic [SHW-1:0] shamt;

  always_comb begin
    shamt = b_i[SHW-1:0];
    or_o  = a_i | b_i;
    and_o = a_i & b_i;
    inv_o = ~a_i;
    xor_o = a_i ^ b_i;
    shr_o = a_i >> shamt;   // logical: zero fill
  end
endmodule

// File: rtl/opmap_alu_select.sv
module opmap_alu_select
  import opmap_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] sum_i,
  input  logic [WIDTH-1:0] diff_i,
  input  logic [WIDTH-1:0] prod_i,
  input  logic [WIDTH-1:0] or_i,
  input  logic [WIDTH-1:0] and_i,
  input  logic [WIDTH-1:0] inv_i,
  input  logic [WIDTH-1:0] xor_i,
  input  logic [WIDTH-1:0] shr_i,
  output logic [WIDTH-1:0] q_o,
  output logic             flag_o
);
  logic is_arith;
  logic is_cmp;

  always_comb begin
    q_o      = '0;
    is_arith = 1'b1;
    is_cmp   = 1'b0;
    case (sel_i)
      OP_ADD:  q_o = sum_i;
      OP_SUB:  q_o = diff_i;
      OP_OR:   q_o = or_i;
      OP_AND:  q_o = and_i;
      OP_NOT:  q_o = inv_i;
      OP_XOR:  q_o = xor_i;
      OP_SHR:  q_o = shr_i;
      OP_MUL:  q_o = prod_i;
      OP_CMP: begin
        is_arith = 1'b0;
        is_cmp   = 1'b1;
      end
      default: is_arith = 1'b0;
    endcase

    if (is_cmp)        flag_o = (a_i == b_i);
    else if (is_arith) flag_o = (q_o == '0);
    else               flag_o = 1'b0;
  end
endmodule

// File: rtl/opmap_alu.sv
module opmap_alu
  import opmap_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] q_o,
  output logic             flag_o
);
  logic [WIDTH-1:0] sum_w, diff_w, prod_w;
  logic [WIDTH-1:0] or_w, and_w, inv_w, xor_w, shr_w;

  opmap_alu_arith #(.WIDTH(WIDTH)) u_arith (
    .a_i(a_i), .b_i(b_i),
    .sum_o(sum_w), .diff_o(diff_w), .prod_o(prod_w)
  );

  opmap_alu_bitops #(.WIDTH(WIDTH)) u_bitops (
    .a_i(a_i), .b_i(b_i),
    .or_o(or_w), .and_o(and_w), .inv_o(inv_w), .xor_o(xor_w), .shr_o(shr_w)
  );

  opmap_alu_select #(.WIDTH(WIDTH)) u_select (
    .sel_i(sel_i), .a_i(a_i), .b_i(b_i),
    .sum_i(sum_w), .diff_i(diff_w), .prod_i(prod_w),
    .or_i(or_w), .and_i(and_w), .inv_i(inv_w), .xor_i(xor_w), .shr_i(shr_w),
    .q_o(q_o), .flag_o(flag_o)
  );
endmodule

// File: rtl/opmap_alu_chk.sv
module opmap_alu_chk
  import opmap_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  localparam int unsigned SHW  = $clog2(WIDTH)
) (
  input logic [SEL_W-1:0] sel_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] q_o,
  input logic             flag_o
);
  localparam logic [WIDTH-1:0] ONES = '1;
  logic [SHW-1:0]   amt;
  logic [WIDTH-1:0] keep_mask;
  logic             known;

  always_comb begin
    amt       = b_i[SHW-1:0];
    keep_mask = ONES << amt;
    known     = !$isunknown({sel_i, a_i, b_i, q_o, flag_o});
    if (known) begin
      // R1: the sum minus b gives back a
      if (sel_i == OP_ADD) assert_add_wrap_R1: assert (q_o - b_i == a_i);
      // R2: the difference plus b gives back a
      if (sel_i == OP_SUB) assert_sub_wrap_R2: assert (q_o + b_i == a_i);
      // R3: covers the OR, AND and XOR codes
      if (sel_i == OP_OR)  assert_or_bits_R3: assert (((q_o & a_i) == a_i) && ((q_o & b_i) == b_i) && ((q_o & ~(a_i | b_i)) == '0));
      if (sel_i == OP_AND) assert_and_bits_R3: assert (((q_o | a_i) == a_i) && ((q_o | b_i) == b_i) && (((a_i & b_i) & ~q_o) == '0));
      if (sel_i == OP_XOR) assert_xor_bits_R3: assert ((q_o ^ b_i) == a_i);
      // R4: the result and a share no set bit and together cover every bit
      if (sel_i == OP_NOT) assert_not_inv_R4: assert (((q_o & a_i) == '0) && ((q_o | a_i) == ONES));
      // R5: shifting back left restores the kept bits of a, and the vacated top bits are zero
      if (sel_i == OP_SHR) assert_shr_zero_fill_R5: assert (((q_o << amt) == (a_i & keep_mask)) && ((q_o & ~(ONES >> amt)) == '0));
      // R7: compare reports equality only
      if (sel_i == OP_CMP) assert_cmp_flag_R7: assert ((q_o == '0) && (flag_o == (a_i == b_i)));
      // R8: arithmetic and logic codes give the zero flag
      if (sel_i == OP_ADD || sel_i == OP_SUB || sel_i == OP_OR || sel_i == OP_AND ||
          sel_i == OP_NOT || sel_i == OP_XOR || sel_i == OP_SHR || sel_i == OP_MUL)
        assert_zero_flag_R8: assert (flag_o == (q_o == '0));
      // R9: non-arithmetic codes give quiet outputs
      if (sel_i == OP_NA0 || sel_i == OP_NA1 || sel_i == OP_NA2 || sel_i == OP_NA9 ||
          sel_i == OP_NA13 || sel_i == OP_NA14 || sel_i == OP_NA15)
        assert_quiet_code_R9: assert ((q_o == '0) && !flag_o);
    end
  end
endmodule

bind opmap_alu opmap_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .sel_i(sel_i), .a_i(a_i), .b_i(b_i), .q_o(q_o), .flag_o(flag_o)
);

// File: tb/opmap_alu_bench.sv
`timescale 1ns/1ps
module opmap_alu_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic [3:0]   sel = '0;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] q;
  logic         flag;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  opmap_alu #(.WIDTH(W)) u_opmap_alu (
    .sel_i(sel), .a_i(a), .b_i(b), .q_o(q), .flag_o(flag)
  );

  function automatic logic [W-1:0] exp_q(input logic [3:0] s, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [2*W-1:0] full;
    full = {{W{1'b0}}, x} * {{W{1'b0}}, y};
    case (s)
      4'b0011: return x + y;
      4'b0100: return x - y;
      4'b0101: return x | y;
      4'b0110: return x & y;
      4'b0111: return ~x;
      4'b1000: return x ^ y;
      4'b1010: return x >> y[3:0];
      4'b1011: return full[W-1:0];
      default: return '0;
    endcase
  endfunction

  function automatic logic exp_flag(input logic [3:0] s, input logic [W-1:0] x, input logic [W-1:0] y);
    case (s)
      4'b1100: return x == y;
      4'b0011, 4'b0100, 4'b0101, 4'b0110, 4'b0111, 4'b1000, 4'b1010, 4'b1011:
        return exp_q(s, x, y) == '0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_q(input logic [3:0] s);
    case (s)
      4'b0011: return "R1";
      4'b0100: return "R2";
      4'b0101, 4'b0110, 4'b1000: return "R3";
      4'b0111: return "R4";
      4'b1010: return "R5";
      4'b1011: return "R6";
      4'b1100: return "R7";
      default: return "R9";
    endcase
  endfunction

  function automatic string tag_f(input logic [3:0] s);
    case (s)
      4'b1100: return "R7";
      4'b0000, 4'b0001, 4'b0010, 4'b1001, 4'b1101, 4'b1110, 4'b1111: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic check_now(input string extra);
    logic [W-1:0] eq;
    logic         ef;
    eq = exp_q(sel, a, b);
    ef = exp_flag(sel, a, b);
    checks++;
    if (q !== eq) begin
      fails++;
      $display("FAIL %s%s q sel=%b a=%h b=%h actual=%h expected=%h", tag_q(sel), extra, sel, a, b, q, eq);
    end
    checks++;
    if (flag !== ef) begin
      fails++;
      $display("FAIL %s%s flag sel=%b a=%h b=%h actual=%b expected=%b", tag_f(sel), extra, sel, a, b, flag, ef);
    end
  endtask

  // drive on the falling edge, sample one ns later
  task automatic apply(input logic [3:0] s, input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    sel = s; a = x; b = y;
    #1;
    check_now("");
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (2) @(negedge clk);
    // reset-like idle state: all zero inputs give quiet outputs (R9)
    #1 check_now(" idle");

    // every code with zero operands (R8 sets flag on zero results)
    for (int s = 0; s < 16; s++) apply(4'(s), '0, '0);
    // R1 wrap
    apply(4'b0011, 16'hFFFF, 16'h0001);
    apply(4'b0011, 16'h8000, 16'h8000);
    // R2 wrap
    apply(4'b0100, 16'h0000, 16'h0001);
    apply(4'b0100, 16'h1234, 16'h1234);
    // R3
    apply(4'b0101, 16'hF0F0, 16'h0F0F);
    apply(4'b0110, 16'hF0F0, 16'h0F0F);
    apply(4'b1000, 16'hA5A5, 16'hA5A5);
    // R4: b has no effect
    apply(4'b0111, 16'hFFFF, 16'h0000);
    apply(4'b0111, 16'hFFFF, 16'h1357);
    apply(4'b0111, 16'h00FF, 16'hFFFF);
    // R5: every distance, upper bits of b set
    for (int k = 0; k < 16; k++) apply(4'b1010, 16'hFFFF, 16'hFFF0 | 16'(k));
    apply(4'b1010, 16'h8001, 16'h000F);
    // R6 truncation
    apply(4'b1011, 16'h0100, 16'h0100);
    apply(4'b1011, 16'hFFFF, 16'hFFFF);
    apply(4'b1011, 16'h1234, 16'h0003);
    // R7
    apply(4'b1100, 16'hBEEF, 16'hBEEF);
    apply(4'b1100, 16'hBEEF, 16'hBEEE);
    apply(4'b1100, 16'h0000, 16'h0000);
    // R9 with all-ones operands
    apply(4'b0000, 16'hFFFF, 16'hFFFF);
    apply(4'b1101, 16'hFFFF, 16'hFFFF);
    apply(4'b1110, 16'h1111, 16'h1111);

    // R10: change inputs while clock stays high, sample with no edge in between
    @(posedge clk);
    #0.5 sel = 4'b0011; a = 16'h0010; b = 16'h0020;
    #0.5 check_now(" R10 no-edge");
    #0.5 sel = 4'b1100; a = 16'h0077; b = 16'h0077;
    #0.5 check_now(" R10 no-edge");

    // constrained random mix over all codes
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] x, y;
      logic [3:0]   s;
      s = 4'($urandom_range(0, 15));
      x = 16'($urandom);
      y = 16'($urandom);
      if (i % 7 == 0) y = x;                 // bias toward equal and zero cases
      if (i % 11 == 0) x = '0;
      apply(s, x, y);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule